// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts a slow, low-power tick delivered as a one-cycle clock enable. A prescaler divides the tick by 32 or by 128. A postscaler then divides that base period by a power of two from 1 to 32768. If the counters run out before the watchdog is kicked, the block raises a one-cycle request. The request is a reset while the device is running. It is a wake-up while the device is in a low-power state.

An optional windowed mode treats an early kick as a fault. In this mode a kick is accepted only in the last quarter of the period. A kick that comes sooner raises the same reset request as a timeout. The watchdog runs either because a static configuration input forces it on, or because software has set an enable bit. That bit is cleared by the system reset and by the block's own reset request. A sticky status flag records that a timeout or a window fault occurred. It stays set until it is cleared explicitly.

Top module: `wdog_window`

## Requirements
- R1: When running with no kick, a reset request `wdt_rst` is high for exactly one cycle every P·2^N ticks. P is the prescale ratio and N is `cfg_post_sel`. The pulse is visible in the cycle after the edge that takes the last tick.
- R2: `cfg_long_pre` = 0 gives P = 32. `cfg_long_pre` = 1 gives P = 128.
- R3: `cfg_post_sel` = N sets the postscale ratio to 2^N, for N from 0 to 15.
- R4: With `cfg_win_off` = 0, a kick is judged by the elapsed position since the last restart. At a position below 3/4 of P·2^N ticks, the kick raises `wdt_rst` one cycle later and restarts the count. At or above that position, the kick only restarts the count.
- R5: With `cfg_win_off` = 1, a kick at any position restarts the count and raises nothing.
- R6: With `cfg_hw_en` = 1, the watchdog always runs, and writes to the software enable bit have no effect on it.
- R7: With `cfg_hw_en` = 0, the watchdog runs only while the software enable bit is 1. That bit is written by `sw_en_we` with `sw_en_wdata`. It is cleared by `rst_n` and by the cycle after a `wdt_rst` pulse.
- R8: While disabled, both counters are held at zero and no request is raised. A kick is ignored.
- R9: A pulse on `sleep_enter` or `clk_switch` restarts both counters, just as a kick does. A restart in the same cycle as a terminal tick suppresses the timeout.
- R10: A timeout while `sleep_active` = 1 raises a one-cycle `wdt_wake` instead of `wdt_rst`.
- R11: `to_flag` is set by every timeout and every window fault. It is cleared by `flag_clr`. If both happen in the same cycle, the set wins.
- R12: During and directly after reset, `wdt_rst`, `wdt_wake` and `to_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_en | input | 1 | One-cycle enable per slow tick |
| cfg_hw_en | input | 1 | Forces the watchdog on |
| cfg_long_pre | input | 1 | Prescale select: 0 → 32, 1 → 128 |
| cfg_post_sel | input | SEL_W | Postscale exponent N |
| cfg_win_off | input | 1 | 1 disables windowed mode |
| sw_en_we | input | 1 | Write strobe for software enable bit |
| sw_en_wdata | input | 1 | Value written to software enable bit |
| kick | input | 1 | Clear-watchdog strobe |
| sleep_enter | input | 1 | Low-power entry strobe |
| sleep_active | input | 1 | Device is in sleep or idle |
| clk_switch | input | 1 | Clock-source change strobe |
| flag_clr | input | 1 | Clears the timeout flag |
| wdt_rst | output | 1 | One-cycle reset request |
| wdt_wake | output | 1 | One-cycle wake request |
| to_flag | output | 1 | Sticky timeout/fault flag |

## Verification
The bench targets the window boundary by kicking one tick before the window opens and again exactly at the opening. A comparator that is off by one would either reset the device on a legal kick or let a premature one through. Each ratio is checked by the exact cycle of the timeout for both prescale choices and a nonzero postscale exponent. A wrong terminal count would move the pulse by whole base periods. The enable paths are checked in two ways. With hardware enable off and software enable off, a kick that would otherwise fault must stay silent. The software bit must also drop after the watchdog's own reset, or a second spurious timeout appears. Sleep behaviour is checked by expecting a wake pulse in place of a reset. The flag is checked for set-over-clear priority in a collision cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_EV_NONE  = 2'd0,
    WD_EV_RESET = 2'd1,
    WD_EV_WAKE  = 2'd2
  } wd_event_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              tick_en,
  input  logic              long_sel,
  output logic [LONG_W-1:0] count,
  output logic              wrap
);
  localparam logic [LONG_W-1:0] LONG_MAX  = {LONG_W{1'b1}};
  localparam logic [LONG_W-1:0] SHORT_MAX = {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [LONG_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = long_sel ? LONG_MAX : SHORT_MAX;
    wrap  = run & tick_en & (cnt_q == limit);
    cnt_d = cnt_q;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      restart,
  input  logic                      step,
  input  logic [SEL_W-1:0]          sel,
  output logic [(1<<SEL_W)-2:0]     count,
  output logic                      ovf
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, term;

  always_comb begin
    term  = ~({CNT_W{1'b1}} << sel);
    ovf   = step & (cnt_q == term);
    cnt_d = cnt_q;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = ovf ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_window_cmp.sv
module wdog_window_cmp #(
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 7,
  parameter int SEL_W   = 4
) (
  input  logic [LONG_W-1:0]         pre_cnt,
  input  logic [(1<<SEL_W)-2:0]     post_cnt,
  input  logic                      long_sel,
  input  logic [SEL_W-1:0]          sel,
  output logic                      open
);
  localparam int CNT_W = (1 << SEL_W) - 1;
  localparam int POS_W = CNT_W + LONG_W;

  logic [POS_W-1:0] pos, thresh;
  logic [7:0]       shamt;

  // Elapsed ticks = post * P + pre; window opens at 3/4 of P * 2^N.
  always_comb begin
    if (long_sel) begin
      pos   = (POS_W'(post_cnt) << LONG_W) | POS_W'(pre_cnt);
      shamt = 8'(sel) + 8'(LONG_W - 2);
    end else begin
      pos   = (POS_W'(post_cnt) << SHORT_W) | POS_W'(pre_cnt[SHORT_W-1:0]);
      shamt = 8'(sel) + 8'(SHORT_W - 2);
    end
    thresh = POS_W'(3) << shamt;
    open   = (pos >= thresh);
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 7,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_hw_en,
  input  logic             cfg_long_pre,
  input  logic [SEL_W-1:0] cfg_post_sel,
  input  logic             cfg_win_off,
  input  logic             sw_en_we,
  input  logic             sw_en_wdata,
  input  logic             kick,
  input  logic             sleep_enter,
  input  logic             sleep_active,
  input  logic             clk_switch,
  input  logic             flag_clr,
  output logic             wdt_rst,
  output logic             wdt_wake,
  output logic             to_flag
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic              run, restart, fault, win_open;
  logic              pre_wrap, post_ovf;
  logic [LONG_W-1:0] pre_cnt;
  logic [CNT_W-1:0]  post_cnt;
  wd_event_e         ev;

  logic sw_en_q, sw_en_d;
  logic rst_q, rst_d, wake_q, wake_d, flag_q, flag_d;

  wdog_prescaler #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .tick_en(tick_en), .long_sel(cfg_long_pre),
    .count(pre_cnt), .wrap(pre_wrap)
  );

  wdog_postscaler #(.SEL_W(SEL_W)) i_post (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .step(pre_wrap), .sel(cfg_post_sel),
    .count(post_cnt), .ovf(post_ovf)
  );

  wdog_window_cmp #(.SHORT_W(SHORT_W), .LONG_W(LONG_W), .SEL_W(SEL_W)) i_win (
    .pre_cnt(pre_cnt), .post_cnt(post_cnt), .long_sel(cfg_long_pre),
    .sel(cfg_post_sel), .open(win_open)
  );

  // Next-state logic
  always_comb begin
    run     = cfg_hw_en | sw_en_q;
    restart = run & (kick | sleep_enter | clk_switch);
    fault   = run & kick & ~cfg_win_off & ~win_open;

    if (fault)                    ev = WD_EV_RESET;
    else if (post_ovf & ~restart) ev = sleep_active ? WD_EV_WAKE : WD_EV_RESET;
    else                          ev = WD_EV_NONE;

    rst_d  = (ev == WD_EV_RESET);
    wake_d = (ev == WD_EV_WAKE);
    flag_d = (ev != WD_EV_NONE) | (flag_q & ~flag_clr);

    sw_en_d = sw_en_q;
    if (rst_q)         sw_en_d = 1'b0;
    else if (sw_en_we) sw_en_d = sw_en_wdata;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      wake_q  <= 1'b0;
      flag_q  <= 1'b0;
      sw_en_q <= 1'b0;
    end else begin
      rst_q   <= rst_d;
      wake_q  <= wake_d;
      flag_q  <= flag_d;
      sw_en_q <= sw_en_d;
    end
  end

  assign wdt_rst  = rst_q;
  assign wdt_wake = wake_q;
  assign to_flag  = flag_q;
endmodule

// File: rtl/wdog_window_sva.sv
module wdog_window_sva #(
  parameter int LONG_W = 7,
  parameter int SEL_W  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wdt_rst,
  input logic                  wdt_wake,
  input logic                  to_flag,
  input logic                  flag_clr,
  input logic                  sleep_active,
  input logic                  cfg_hw_en,
  input logic                  sw_en_q,
  input logic [LONG_W-1:0]     pre_cnt,
  input logic [(1<<SEL_W)-2:0] post_cnt
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(wdt_rst && wdt_wake)); // R10
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) wdt_wake |-> $past(sleep_active)); // R10
  AST_FLAG_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n) (wdt_rst || wdt_wake) |-> to_flag); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (to_flag && !flag_clr) |=> to_flag); // R11
  AST_SW_DROPS: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |=> !sw_en_q); // R7
  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_hw_en || sw_en_q) |=> (pre_cnt == '0 && post_cnt == '0)); // R8
endmodule

bind wdog_window wdog_window_sva #(.LONG_W(LONG_W), .SEL_W(SEL_W)) i_wdog_window_sva (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .wdt_wake(wdt_wake),
  .to_flag(to_flag), .flag_clr(flag_clr), .sleep_active(sleep_active),
  .cfg_hw_en(cfg_hw_en), .sw_en_q(sw_en_q), .pre_cnt(pre_cnt), .post_cnt(post_cnt)
);

// File: tb/test_wdog_window.sv
module test_wdog_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic cfg_hw_en = 1'b1, cfg_long_pre = 1'b0, cfg_win_off = 1'b1;
  logic [3:0] cfg_post_sel = 4'd0;
  logic sw_en_we = 1'b0, sw_en_wdata = 1'b0, kick = 1'b0;
  logic sleep_enter = 1'b0, sleep_active = 1'b0, clk_switch = 1'b0, flag_clr = 1'b0;
  logic wdt_rst, wdt_wake, to_flag;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic slow_tick = 1'b0;

  typedef struct { int kind; int lo; int hi; string tag; } exp_t;
  exp_t sb_q[$];

  wdog_window i_wdog_window (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_hw_en(cfg_hw_en),
    .cfg_long_pre(cfg_long_pre), .cfg_post_sel(cfg_post_sel), .cfg_win_off(cfg_win_off),
    .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata), .kick(kick),
    .sleep_enter(sleep_enter), .sleep_active(sleep_active), .clk_switch(clk_switch),
    .flag_clr(flag_clr), .wdt_rst(wdt_rst), .wdt_wake(wdt_wake), .to_flag(to_flag)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) tick_en = slow_tick ? (cyc % 4 == 0) : 1'b1;

  // Monitor: compare observed requests against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && (wdt_rst || wdt_wake)) begin
      int kind;
      kind = wdt_rst ? (wdt_wake ? 3 : 1) : 2;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected request: actual kind=%0d cycle=%0d, expected none", kind, cyc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (kind != e.kind || cyc < e.lo || cyc > e.hi) begin
          fails++;
          $display("FAIL %s: actual kind=%0d cycle=%0d, expected kind=%0d cycle=%0d..%0d",
                   e.tag, kind, cyc, e.kind, e.lo, e.hi);
        end
      end
    end
  end

  task automatic expect_ev(input int kind, input int lo, input int hi, input string tag);
    exp_t e;
    e.kind = kind; e.lo = lo; e.hi = hi; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drained(input string tag);
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL %s: actual pending=%0d expected 0", tag, sb_q.size());
      sb_q.delete();
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic restart_dut(input logic hw, input logic lp, input logic [3:0] ps,
                             input logic woff, output int c);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_hw_en = hw; cfg_long_pre = lp; cfg_post_sel = ps; cfg_win_off = woff;
    @(negedge clk);
    rst_n = 1'b1;
    c = cyc;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int c, s;
    repeat (3) @(negedge clk);
    // R12 reset state
    check_bit(wdt_rst, 1'b0, "R12 rst in reset");
    check_bit(wdt_wake, 1'b0, "R12 wake in reset");
    check_bit(to_flag, 1'b0, "R12 flag in reset");

    // R1 / R3 N=0, short prescale: periodic reset every 32 ticks
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    check_bit(wdt_rst, 1'b0, "R12 rst after release");
    expect_ev(1, c + 32, c + 32, "R1 first timeout");
    expect_ev(1, c + 64, c + 64, "R1 second timeout");
    wait_until(c + 65);
    check_bit(to_flag, 1'b1, "R11 flag after timeout");
    pulse(flag_clr);
    check_bit(to_flag, 1'b0, "R11 flag cleared");
    drained("R1 drained");

    // R2 long prescale
    restart_dut(1'b1, 1'b1, 4'd0, 1'b1, c);
    expect_ev(1, c + 128, c + 128, "R2 long prescale");
    wait_until(c + 130);
    drained("R2 drained");

    // R3 postscale 2^3 with short prescale
    restart_dut(1'b1, 1'b0, 4'd3, 1'b1, c);
    expect_ev(1, c + 256, c + 256, "R3 postscale 8");
    wait_until(c + 258);
    drained("R3 drained");

    // R4 window boundary: accepted at 24, fault at 23
    restart_dut(1'b1, 1'b0, 4'd0, 1'b0, c);
    wait_until(c + 24);
    pulse(kick);
    wait_until(c + 48);
    expect_ev(1, c + 49, c + 49, "R4 early kick fault");
    pulse(kick);
    check_bit(to_flag, 1'b1, "R11 flag after fault");
    expect_ev(1, c + 81, c + 81, "R4 timeout after fault");
    wait_until(c + 83);
    drained("R4 drained");

    // R5 window off: early kicks accepted
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    wait_until(c + 5);
    pulse(kick);
    wait_until(c + 26);
    pulse(kick);
    expect_ev(1, c + 59, c + 59, "R5 open kicks restart");
    wait_until(c + 61);
    drained("R5 drained");

    // R6 hardware enable overrides a software write of 0
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    wait_until(c + 3);
    sw_en_wdata = 1'b0;
    pulse(sw_en_we);
    expect_ev(1, c + 32, c + 32, "R6 hw enable keeps running");
    wait_until(c + 34);
    drained("R6 drained");

    // R8 disabled: no requests, kick (would be early) ignored
    restart_dut(1'b0, 1'b0, 4'd0, 1'b0, c);
    wait_until(c + 10);
    pulse(kick);
    wait_until(c + 100);
    drained("R8 disabled quiet");
    check_bit(to_flag, 1'b0, "R8 flag untouched");

    // R7 software enable, self-clear after own reset
    s = cyc;
    sw_en_wdata = 1'b1;
    expect_ev(1, s + 33, s + 33, "R7 sw enabled timeout");
    pulse(sw_en_we);
    wait_until(s + 140);
    drained("R7 sw bit dropped after reset");
    s = cyc;
    expect_ev(1, s + 33, s + 33, "R7 sw re-enable");
    pulse(sw_en_we);
    wait_until(s + 60);
    pulse(sw_en_we);
    wait_until(s + 70);
    restart_dut(1'b0, 1'b0, 4'd0, 1'b1, c);
    wait_until(c + 100);
    drained("R7 rst_n clears sw bit");

    // R9 clock switch and sleep entry restart the count
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    wait_until(c + 20);
    pulse(clk_switch);
    expect_ev(1, c + 53, c + 53, "R9 clock switch restart");
    wait_until(c + 60);
    pulse(sleep_enter);
    expect_ev(1, c + 93, c + 93, "R9 sleep entry restart");
    wait_until(c + 95);
    drained("R9 drained");

    // R9 restart in same cycle as terminal tick suppresses timeout
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    wait_until(c + 31);
    pulse(clk_switch);
    expect_ev(1, c + 64, c + 64, "R9 collision suppressed");
    wait_until(c + 66);
    drained("R9 collision drained");

    // R10 wake instead of reset while asleep
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    wait_until(c + 5);
    sleep_active = 1'b1;
    pulse(sleep_enter);
    expect_ev(2, c + 38, c + 38, "R10 wake while asleep");
    wait_until(c + 39);
    check_bit(to_flag, 1'b1, "R11 flag after wake");
    sleep_active = 1'b0;
    drained("R10 drained");

    // R11 set beats clear in the same cycle
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    expect_ev(1, c + 32, c + 32, "R11 collision timeout");
    wait_until(c + 31);
    pulse(flag_clr);
    check_bit(to_flag, 1'b1, "R11 set wins over clear");
    pulse(flag_clr);
    check_bit(to_flag, 1'b0, "R11 later clear");
    drained("R11 drained");

    // R1 with sparse ticks: period counted in ticks, not clocks
    slow_tick = 1'b1;
    restart_dut(1'b1, 1'b0, 4'd0, 1'b1, c);
    expect_ev(1, c + 120, c + 136, "R1 sparse tick period");
    wait_until(c + 140);
    drained("R1 sparse drained");
    slow_tick = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule